// File: doc/BRIEF.md
# Serial Flash Command Front End

This block sits at the host-facing edge of a serial flash slave and turns the raw SPI pins into a decoded instruction. It samples SCK, the active-low chip select and the four IO lines in the core clock domain, finds SCK rising edges while the slave is selected, and shifts in an 8-bit instruction. The instruction arrives one bit per SCK edge on IO0 in legacy mode, or one nibble per edge on IO0..IO3 when the quad-instruction configuration bit is set at the start of the command.

Once the eighth bit is in, a small opcode table picks what the rest of the command looks like. The choices are more host-to-memory input, a latency wait, an output phase, or a hold state. The hold state covers commands that stand alone and opcodes the table does not know. A stand-alone command is committed only when chip select rises cleanly after the instruction. The write-protect pin is sampled together with the last instruction bit, and only for the two register-write opcodes. The IO output enables stay off everywhere except in the output phase.

Top module: `flash_cmd_frontend`

## Requirements
- R1: After reset, `phase` is 0 (standby), `io_oe` is 0, and `instr_done`, `cmd_commit` and `wp_valid` are low.
- R2: In legacy mode, each SCK rising edge while `cs_n` is low shifts `io_in[0]` into the instruction, MSB first. The eighth edge gives a one-cycle `instr_done` pulse with the byte on `instr_code`. While capture is under way, `phase` is 1.
- R3: If `qpi_cfg` is 1 when `cs_n` falls, each edge shifts in a nibble with `io_in[3]` as its most significant bit, so the byte completes on the second edge. `quad_mode` reports the latched setting.
- R4: At `instr_done`, `phase` takes the opcode's class. Opcodes 03h, 0Bh, 02h, 01h, 71h and D8h give 2 (input). Opcode 5Ah gives 3 (latency). Opcodes 05h, 07h, 35h and 9Fh give 4 (output). Opcodes 06h, 04h, B9h, ABh and 60h (stand-alone), and every other opcode, give 5 (hold).
- R5: For a stand-alone opcode, `cs_n` rising with no SCK edge after the eighth bit gives a one-cycle `cmd_commit` pulse with the opcode still on `instr_code`, and `phase` returns to 0.
- R6: A stand-alone command that sees any further SCK rising edge before `cs_n` rises is not committed.
- R7: An opcode that is not in the table holds `phase` at 5 until `cs_n` rises and never gives `cmd_commit`.
- R8: If `cs_n` rises before the eighth bit, the instruction is dropped. There is no `instr_done`, `phase` goes to 0, and the next command is captured from a fresh start.
- R9: An SCK rising edge that is sampled while `cs_n` is high has no effect. This includes an edge sampled in the same cycle that `cs_n` is seen rising.
- R10: `wp_valid` pulses together with `instr_done` only for opcodes 01h and 71h. `wp_level` then holds `wp_n` as sampled with the last instruction bit.
- R11: `io_oe` (bit n enables IO n) is 0 in every phase other than output. In the output phase it is 0010b (IO1 only) in legacy mode and 1111b in quad mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples all pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| io_in | input | 4 | IO lines as seen at the pads; IO0 is the single serial input |
| wp_n | input | 1 | Write-protect pin level |
| qpi_cfg | input | 1 | Quad-instruction configuration bit |
| io_oe | output | 4 | Output enable per IO line |
| phase | output | 3 | Current interface phase code |
| quad_mode | output | 1 | Lane width latched at the start of the command |
| instr_done | output | 1 | One-cycle pulse when the eighth instruction bit is in |
| instr_code | output | 8 | Last complete instruction byte |
| wp_valid | output | 1 | One-cycle pulse when a write-protect sample is taken |
| wp_level | output | 1 | Sampled write-protect level |
| cmd_commit | output | 1 | One-cycle pulse when a stand-alone command completes |

## Verification
Two events can land in the same sampled core cycle: the SCK edge that would complete the instruction, and the rise of chip select. The bench shifts in seven legacy bits and then, at one clock step, raises SCK and `cs_n` together. The required result is that deselection wins. No `instr_done` may appear, `phase` must be back at 0, and the monitor flags any stray completion left in the scoreboard. A clean command that follows confirms that the capture started over from a fresh state.

// File: rtl/fic_pkg.sv
package fic_pkg;

  localparam int unsigned INSTR_BITS = 8;
  localparam int unsigned LANES      = 4;

  typedef enum logic [2:0] {
    PH_STANDBY = 3'd0,
    PH_INSTR   = 3'd1,
    PH_INPUT   = 3'd2,
    PH_LATENCY = 3'd3,
    PH_OUTPUT  = 3'd4,
    PH_HOLD    = 3'd5
  } phase_e;

  typedef enum logic [2:0] {
    OC_SOLO,
    OC_INPUT,
    OC_LATENCY,
    OC_OUTPUT,
    OC_UNKNOWN
  } op_class_e;

  // Opcode table: what follows the instruction byte.
  function automatic op_class_e classify(input logic [INSTR_BITS-1:0] op);
    case (op)
      8'h06, 8'h04, 8'hB9, 8'hAB, 8'h60:        classify = OC_SOLO;
      8'h03, 8'h0B, 8'h02, 8'h01, 8'h71, 8'hD8: classify = OC_INPUT;
      8'h5A:                                    classify = OC_LATENCY;
      8'h05, 8'h07, 8'h35, 8'h9F:               classify = OC_OUTPUT;
      default:                                  classify = OC_UNKNOWN;
    endcase
  endfunction

  function automatic phase_e phase_of(input op_class_e c);
    case (c)
      OC_INPUT:   phase_of = PH_INPUT;
      OC_LATENCY: phase_of = PH_LATENCY;
      OC_OUTPUT:  phase_of = PH_OUTPUT;
      default:    phase_of = PH_HOLD;
    endcase
  endfunction

  // Register-write opcodes are the only ones that look at write protect.
  function automatic logic takes_wp(input logic [INSTR_BITS-1:0] op);
    takes_wp = (op == 8'h01) || (op == 8'h71);
  endfunction

  function automatic logic [LANES-1:0] oe_pattern(input logic quad);
    oe_pattern = quad ? {LANES{1'b1}} : LANES'(2);
  endfunction

endpackage

// File: rtl/fic_pin_sampler.sv
module fic_pin_sampler #(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck,
  input  logic             cs_n,
  input  logic [LANES-1:0] io_in,
  input  logic             wp_n,
  output logic             sck_rise,
  output logic             cs_fall,
  output logic             cs_rise,
  output logic             cs_high,
  output logic [LANES-1:0] io_s,
  output logic             wp_s
);

  logic sck_s, sck_q, cs_s, cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= 1'b0;
      sck_q <= 1'b0;
      cs_s  <= 1'b1;
      cs_q  <= 1'b1;
      io_s  <= '0;
      wp_s  <= 1'b1;
    end else begin
      sck_s <= sck;
      sck_q <= sck_s;
      cs_s  <= cs_n;
      cs_q  <= cs_s;
      io_s  <= io_in;
      wp_s  <= wp_n;
    end
  end

  // An SCK edge counts only when chip select is seen low in the same sample.
  assign sck_rise = sck_s & ~sck_q & ~cs_s;
  assign cs_fall  = ~cs_s & cs_q;
  assign cs_rise  = cs_s & ~cs_q;
  assign cs_high  = cs_s;

endmodule

// File: rtl/fic_instr_shifter.sv
module fic_instr_shifter #(
  parameter int unsigned INSTR_BITS = 8,
  parameter int unsigned LANES      = 4,
  localparam int unsigned CNT_W     = $clog2(INSTR_BITS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_fall,
  input  logic                  cs_high,
  input  logic                  sck_rise,
  input  logic                  capture_en,
  input  logic                  quad,
  input  logic [LANES-1:0]      io_s,
  output logic                  byte_done,
  output logic [INSTR_BITS-1:0] byte_val
);

  logic [INSTR_BITS-1:0] sh_q;
  logic [CNT_W-1:0]      cnt_q, step, cnt_nxt;
  logic                  take;

  assign take     = sck_rise & capture_en;
  assign step     = quad ? CNT_W'(LANES) : CNT_W'(1);
  assign cnt_nxt  = cnt_q + step;
  // MSB first in both widths; in quad the top lane is the nibble MSB.
  assign byte_val = quad ? {sh_q[INSTR_BITS-LANES-1:0], io_s}
                         : {sh_q[INSTR_BITS-2:0], io_s[0]};
  assign byte_done = take & (cnt_nxt == CNT_W'(INSTR_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (cs_fall) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (take) begin
      sh_q  <= byte_val;
      cnt_q <= cnt_nxt;
    end
  end

  AST_QUAD_NIBBLE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (take && quad) |=> ((cnt_q % CNT_W'(LANES)) == '0)); // R3
  AST_DESELECT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_high |=> $stable(sh_q)); // R9

endmodule

// File: rtl/fic_phase_ctrl.sv
module fic_phase_ctrl
  import fic_pkg::*;
#(
  parameter int unsigned INSTR_BITS = 8,
  parameter int unsigned LANES      = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_fall,
  input  logic                  cs_rise,
  input  logic                  cs_high,
  input  logic                  sck_rise,
  input  logic                  byte_done,
  input  logic [INSTR_BITS-1:0] byte_val,
  input  logic                  wp_s,
  input  logic                  qpi_cfg,
  output phase_e                phase_q,
  output logic                  quad_q,
  output logic                  capture_en,
  output logic                  instr_done,
  output logic [INSTR_BITS-1:0] instr_code,
  output logic                  wp_valid,
  output logic                  wp_level,
  output logic                  cmd_commit,
  output logic [LANES-1:0]      io_oe
);

  logic      solo_ok_q;
  op_class_e cls;

  assign cls        = classify(byte_val);
  assign capture_en = (phase_q == PH_INSTR);
  assign io_oe      = (phase_q == PH_OUTPUT) ? oe_pattern(quad_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_STANDBY;
      quad_q     <= 1'b0;
      solo_ok_q  <= 1'b0;
      instr_done <= 1'b0;
      instr_code <= '0;
      wp_valid   <= 1'b0;
      wp_level   <= 1'b1;
      cmd_commit <= 1'b0;
    end else begin
      instr_done <= 1'b0;
      wp_valid   <= 1'b0;
      cmd_commit <= 1'b0;
      if (cs_high) begin
        cmd_commit <= cs_rise && (phase_q == PH_HOLD) && solo_ok_q;
        phase_q    <= PH_STANDBY;
        solo_ok_q  <= 1'b0;
      end else begin
        case (phase_q)
          PH_STANDBY: if (cs_fall) begin
            phase_q <= PH_INSTR;
            quad_q  <= qpi_cfg;
          end
          PH_INSTR: if (byte_done) begin
            phase_q    <= phase_of(cls);
            instr_done <= 1'b1;
            instr_code <= byte_val;
            solo_ok_q  <= (cls == OC_SOLO);
            wp_valid   <= takes_wp(byte_val);
            wp_level   <= wp_s;
          end
          PH_HOLD: if (sck_rise) solo_ok_q <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  AST_DONE_FROM_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |-> ($past(phase_q) == PH_INSTR)); // R2
  AST_COMMIT_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_commit |-> ($past(phase_q) == PH_HOLD) && (phase_q == PH_STANDBY)); // R5
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({instr_done, cmd_commit})); // R5
  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_high |=> (phase_q == PH_STANDBY)); // R8
  AST_WP_ONLY_REGWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wp_valid |-> instr_done && ((instr_code == 8'h01) || (instr_code == 8'h71))); // R10
  AST_QUIET_HOST_PHASES: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q inside {PH_STANDBY, PH_INSTR, PH_INPUT, PH_LATENCY, PH_HOLD}) |-> (io_oe == '0)); // R11

endmodule

// File: rtl/flash_cmd_frontend.sv
module flash_cmd_frontend
  import fic_pkg::*;
#(
  parameter int unsigned INSTR_W = fic_pkg::INSTR_BITS,
  parameter int unsigned IO_W    = fic_pkg::LANES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sck,
  input  logic               cs_n,
  input  logic [IO_W-1:0]    io_in,
  input  logic               wp_n,
  input  logic               qpi_cfg,
  output logic [IO_W-1:0]    io_oe,
  output logic [2:0]         phase,
  output logic               quad_mode,
  output logic               instr_done,
  output logic [INSTR_W-1:0] instr_code,
  output logic               wp_valid,
  output logic               wp_level,
  output logic               cmd_commit
);

  // Named internal events, visible to assertions.
  logic              ev_sck_rise, ev_cs_fall, ev_cs_rise, ev_cs_high;
  logic [IO_W-1:0]   io_s;
  logic              wp_s;
  logic              capture_en, byte_done;
  logic [INSTR_W-1:0] byte_val;
  phase_e            phase_q;

  fic_pin_sampler #(.LANES(IO_W)) u_sampler (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .io_in(io_in), .wp_n(wp_n),
    .sck_rise(ev_sck_rise), .cs_fall(ev_cs_fall), .cs_rise(ev_cs_rise),
    .cs_high(ev_cs_high), .io_s(io_s), .wp_s(wp_s)
  );

  fic_instr_shifter #(.INSTR_BITS(INSTR_W), .LANES(IO_W)) u_shifter (
    .clk(clk), .rst_n(rst_n), .cs_fall(ev_cs_fall), .cs_high(ev_cs_high),
    .sck_rise(ev_sck_rise), .capture_en(capture_en), .quad(quad_mode),
    .io_s(io_s), .byte_done(byte_done), .byte_val(byte_val)
  );

  fic_phase_ctrl #(.INSTR_BITS(INSTR_W), .LANES(IO_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_fall(ev_cs_fall), .cs_rise(ev_cs_rise),
    .cs_high(ev_cs_high), .sck_rise(ev_sck_rise), .byte_done(byte_done),
    .byte_val(byte_val), .wp_s(wp_s), .qpi_cfg(qpi_cfg), .phase_q(phase_q),
    .quad_q(quad_mode), .capture_en(capture_en), .instr_done(instr_done),
    .instr_code(instr_code), .wp_valid(wp_valid), .wp_level(wp_level),
    .cmd_commit(cmd_commit), .io_oe(io_oe)
  );

  assign phase = phase_q;

  AST_NO_DONE_WHILE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cs_high |=> !instr_done); // R9
  AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> (phase == 3'd0) && (io_oe == '0)); // R1

endmodule

// File: tb/flash_cmd_frontend_test.sv
module flash_cmd_frontend_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0;
  logic       cs_n = 1'b1;
  logic [3:0] io_in = 4'hF;
  logic       wp_n = 1'b1;
  logic       qpi_cfg = 1'b0;
  logic [3:0] io_oe;
  logic [2:0] phase;
  logic       quad_mode, instr_done, wp_valid, wp_level, cmd_commit;
  logic [7:0] instr_code;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  logic [12:0] exp_done_q[$];   // {code, phase, wp_valid, wp_level}
  logic [7:0]  exp_commit_q[$];

  always #2 clk = ~clk;   // 250 MHz

  flash_cmd_frontend uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .io_in(io_in), .wp_n(wp_n),
    .qpi_cfg(qpi_cfg), .io_oe(io_oe), .phase(phase), .quad_mode(quad_mode),
    .instr_done(instr_done), .instr_code(instr_code), .wp_valid(wp_valid),
    .wp_level(wp_level), .cmd_commit(cmd_commit)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Bench's own view of the opcode classes (R4).
  function automatic logic [2:0] expect_phase(input logic [7:0] op);
    if (op inside {8'h03, 8'h0B, 8'h02, 8'h01, 8'h71, 8'hD8}) return 3'd2;
    if (op == 8'h5A) return 3'd3;
    if (op inside {8'h05, 8'h07, 8'h35, 8'h9F}) return 3'd4;
    return 3'd5;
  endfunction

  function automatic bit is_solo(input logic [7:0] op);
    return op inside {8'h06, 8'h04, 8'hB9, 8'hAB, 8'h60};
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sck();
    wait_clk(2); sck = 1'b1; wait_clk(4); sck = 1'b0; wait_clk(2);
  endtask

  // Monitor: pops expected events as the design produces them.
  always begin
    @(posedge clk); #1;
    if (rst_n && instr_done) begin
      if (exp_done_q.size() == 0)
        check(1'b0, "R8 unexpected instr_done", {24'd0, instr_code}, 32'd0);
      else begin
        logic [12:0] e;
        logic [12:0] a;
        e = exp_done_q.pop_front();
        a = {instr_code, phase, wp_valid, wp_valid & wp_level};
        check(a == e, "R2/R3/R4/R10 instruction event", {19'd0, a}, {19'd0, e});
      end
    end
    if (rst_n && cmd_commit) begin
      if (exp_commit_q.size() == 0)
        check(1'b0, "R6/R7 unexpected cmd_commit", {24'd0, instr_code}, 32'd0);
      else begin
        logic [7:0] c;
        c = exp_commit_q.pop_front();
        check(instr_code == c && phase == 3'd0, "R5 commit", {21'd0, phase, instr_code}, {24'd0, c});
      end
    end
  end

  task automatic send_cmd(input logic [7:0] op, input bit quad, input bit wp, input bit extra);
    logic [2:0] ph;
    bit wpv;
    ph  = expect_phase(op);
    wpv = (op == 8'h01) || (op == 8'h71);
    exp_done_q.push_back({op, ph, wpv, wpv & wp});
    if (is_solo(op) && !extra) exp_commit_q.push_back(op);
    qpi_cfg = quad;
    wp_n = wp;
    cs_n = 1'b0;
    wait_clk(4);
    if (quad) begin
      io_in = op[7:4]; pulse_sck();
      check(phase == 3'd1 && io_oe == 4'h0, "R3 mid-capture phase/oe", {28'd0, phase, 1'b0}, 32'd2);
      io_in = op[3:0]; pulse_sck();
    end else begin
      for (int i = 7; i >= 0; i--) begin
        io_in = {3'b111, op[i]};
        pulse_sck();
        if (i == 4) check(phase == 3'd1 && io_oe == 4'h0, "R11 oe off during capture",
                          {24'd0, io_oe, 1'b0, phase}, 32'd1);
      end
    end
    wait_clk(2);
    check(phase == ph, "R4 phase before deselect", {29'd0, phase}, {29'd0, ph});
    check(io_oe == ((ph == 3'd4) ? (quad ? 4'hF : 4'h2) : 4'h0), "R11 io_oe",
          {28'd0, io_oe}, {28'd0, (ph == 3'd4) ? (quad ? 4'hF : 4'h2) : 4'h0});
    if (extra) pulse_sck();
    wait_clk(2);
    cs_n = 1'b1;
    wait_clk(6);
    check(phase == 3'd0 && io_oe == 4'h0, "R5/R7 back to standby", {28'd0, io_oe[0], phase}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    check(phase == 3'd0 && io_oe == 4'h0 && !instr_done && !cmd_commit && !wp_valid,
          "R1 reset state", {25'd0, io_oe, phase}, 32'd0);
    rst_n = 1'b1;
    wait_clk(4);
    check(phase == 3'd0 && io_oe == 4'h0, "R1 after reset release", {25'd0, io_oe, phase}, 32'd0);

    send_cmd(8'h06, 1'b0, 1'b1, 1'b0);   // R5 stand-alone legacy
    send_cmd(8'h03, 1'b0, 1'b1, 1'b0);   // R2 R4 input
    send_cmd(8'h9F, 1'b0, 1'b1, 1'b0);   // R11 legacy output
    send_cmd(8'h05, 1'b1, 1'b1, 1'b0);   // R3 R11 quad output
    send_cmd(8'h5A, 1'b1, 1'b1, 1'b0);   // R4 latency
    send_cmd(8'hB9, 1'b1, 1'b1, 1'b0);   // R3 R5 quad stand-alone
    send_cmd(8'h60, 1'b0, 1'b1, 1'b1);   // R6 extra edge, no commit
    send_cmd(8'h42, 1'b0, 1'b1, 1'b0);   // R7 unknown
    send_cmd(8'hA5, 1'b1, 1'b1, 1'b1);   // R7 unknown with extra edge
    send_cmd(8'h01, 1'b0, 1'b0, 1'b0);   // R10 WP low sample
    send_cmd(8'h71, 1'b1, 1'b1, 1'b0);   // R10 WP high sample
    send_cmd(8'h35, 1'b0, 1'b0, 1'b0);   // R10 no sample for other opcode

    // R8: abort after five bits
    qpi_cfg = 1'b0; cs_n = 1'b0; wait_clk(4);
    for (int i = 0; i < 5; i++) begin io_in = {3'b111, i[0]}; pulse_sck(); end
    cs_n = 1'b1; wait_clk(6);
    check(phase == 3'd0, "R8 abort returns to standby", {29'd0, phase}, 32'd0);
    send_cmd(8'h04, 1'b0, 1'b1, 1'b0);   // R8 fresh capture after abort

    // R9: eighth edge and deselect seen in the same sample
    cs_n = 1'b0; wait_clk(4);
    for (int i = 0; i < 7; i++) begin io_in = 4'hF; pulse_sck(); end
    wait_clk(2);
    sck = 1'b1; cs_n = 1'b1;
    wait_clk(4); sck = 1'b0; wait_clk(4);
    check(phase == 3'd0 && exp_done_q.size() == 0, "R9 coincident edge ignored", {29'd0, phase}, 32'd0);
    // R9: SCK toggling while deselected
    for (int i = 0; i < 8; i++) pulse_sck();
    check(phase == 3'd0, "R9 deselected clocks ignored", {29'd0, phase}, 32'd0);
    send_cmd(8'hAB, 1'b0, 1'b1, 1'b0);   // R9 clean capture afterwards

    wait_clk(10);
    check(exp_done_q.size() == 0, "R2 all instruction events seen", exp_done_q.size(), 32'd0);
    check(exp_commit_q.size() == 0, "R5 all commits seen", exp_commit_q.size(), 32'd0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule